// File: doc/BRIEF.md
# Dual-Record Error Syndrome Logger

This block gathers memory error events from two groups of RAMs and keeps a syndrome for each group. One record serves the RAMs private to a core. The other serves the shared cache and snoop-filter RAMs. Each record keeps the location of the first error it sees. After that it only counts: a later error at the same location adds to a repeat counter, and any other error adds to an other-error counter. An overflow flag shows that errors arrived in the same cycle.

Software reaches both records through a small register port. A select register chooses which record the status, misc and control addresses refer to. Each record drives a fault interrupt for any logged error and an error interrupt for uncorrectable errors, and each interrupt has its own enable bit. Software clears the interrupts by writing zeros to the status flags. A warm reset leaves the logged syndromes in place, so software can read them after the restart.

Register map (32-bit data):
- Address 0 is the select register. Bit 0 = 0 selects the private record and bit 0 = 1 selects the shared record.
- Address 1 is the control register of the selected record. Bit 0 enables the fault interrupt and bit 1 enables the error interrupt.
- Address 2 is the status of the selected record. Bit 31 is valid, bit 30 is uncorrectable and bit 29 is overflow.
- Address 3 is the misc word of the selected record. Bits 7:0 hold the index, bits 11:8 the way, bits 13:12 the level, bits 21:14 the other-error count and bits 29:22 the repeat count.

Top module: `err_syndrome_logger`

## Requirements
- R1: With the record empty, one error captures its level, way and index into misc. Status then reads valid = 1 (bit 31) with both counters at 0, and the uncorrectable flag (bit 30) is set if that error was uncorrectable.
- R2: When several errors reach an empty record in one cycle, the lowest-numbered source is captured and the overflow flag (bit 29) is set. The other-error count becomes 1, however many extra errors there were.
- R3: While valid is set, the location fields do not change. An error matching the stored level, way and index adds one to the repeat count (misc bits 29:22). A non-matching error adds one to the other-error count (misc bits 21:14).
- R4: When several errors reach a valid record in one cycle, the repeat count and the other-error count each rise by at most one, and the overflow flag is set.
- R5: Both counters saturate at 255.
- R6: Private-RAM events update only record 0 and shared-RAM events update only record 1. Reads and writes at addresses 1, 2 and 3 act on the record chosen by select bit 0, and address 0 reads back the select value.
- R7: `fault_irq[r]` is high whenever record r is valid and its control bit 0 is set, starting from the cycle after the error is captured.
- R8: `err_irq[r]` is high whenever record r holds an uncorrectable error and its control bit 1 is set. It stays high until software writes status with bit 30 = 0. A write with bit 30 = 1 leaves it unchanged.
- R9: A status write with bit 31 = 0 clears the whole record, after which the next error is captured as a first error. A write with bit 29 = 0 clears only the overflow flag.
- R10: A warm reset sets the select and control registers to 0 and keeps the contents of both records. A cold reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, active high; clears everything |
| warm_rst | input | 1 | Synchronous warm reset, active high; clears only select and control |
| prv_ev_vld | input | NUM_PRIV | Error strobe from each private RAM |
| prv_ev_ue | input | NUM_PRIV | Uncorrectable qualifier for each private RAM |
| prv_ev_lvl | input | NUM_PRIV*2 | Level of each private error, packed by source |
| prv_ev_way | input | NUM_PRIV*4 | Way of each private error |
| prv_ev_idx | input | NUM_PRIV*8 | Index of each private error |
| shr_ev_vld | input | NUM_SHR | Error strobe from each shared RAM |
| shr_ev_ue | input | NUM_SHR | Uncorrectable qualifier for each shared RAM |
| shr_ev_lvl | input | NUM_SHR*2 | Level of each shared error |
| shr_ev_way | input | NUM_SHR*4 | Way of each shared error |
| shr_ev_idx | input | NUM_SHR*8 | Index of each shared error |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| fault_irq | output | 2 | Fault interrupt per record (0 private, 1 shared) |
| err_irq | output | 2 | Error interrupt per record |

## Verification
Each record state element appears at the ports one cycle after the event that updates it. The flags show in the status word and drive the interrupts. Location and counters show in the misc word. A wrong priority pick shows as the wrong location in misc, and a missing location lock shows as changed location fields after a later error. A counter that steps by two, wraps, or counts the extra same-cycle errors shows in misc right after the collision cycle. The warm and cold reset checks read both records back through the select register, so retained state and lost state can be told apart.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int LVL_W = 2;
    localparam int WAY_W = 4;
    localparam int IDX_W = 8;
    localparam int CNT_W = 8;
    localparam int CSR_W = 32;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [WAY_W-1:0] way;
        logic [IDX_W-1:0] idx;
    } err_loc_t;

    localparam int LOC_W  = $bits(err_loc_t);
    localparam int MISC_W = LOC_W + 2 * CNT_W;

    typedef struct packed {
        logic             v;
        logic             ue;
        logic             of;
        err_loc_t         loc;
        logic [CNT_W-1:0] rpt;
        logic [CNT_W-1:0] oth;
    } err_rec_t;

    typedef enum logic [1:0] {
        CSR_SEL  = 2'd0,
        CSR_CTL  = 2'd1,
        CSR_STAT = 2'd2,
        CSR_MISC = 2'd3
    } csr_addr_e;

    localparam int ST_V  = CSR_W - 1;
    localparam int ST_UE = CSR_W - 2;
    localparam int ST_OF = CSR_W - 3;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c, input logic en);
        return (en && (c != '1)) ? c + 1'b1 : c;
    endfunction

endpackage

// File: rtl/errlog_pick.sv
module errlog_pick #(
    parameter int N = 4,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vld,
    output logic          any,
    output logic          multi,
    output logic [SW-1:0] first
);

    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld[i]) first = SW'(i);
        end
    end

    assign any   = |vld;
    assign multi = $countones(vld) > 1;

    always_comb begin
        if (any) begin
            // R2
            pick_is_active_chk: assert (vld[first]);
        end
    end

endmodule

// File: rtl/errlog_record.sv
module errlog_record import errlog_pkg::*; #(
    parameter int N = 4
) (
    input  logic               clk,
    input  logic               cold_rst,
    input  logic [N-1:0]       ev_vld,
    input  logic [N-1:0]       ev_ue,
    input  err_loc_t [N-1:0]   ev_loc,
    input  logic               stat_we,
    input  logic               wr_v,
    input  logic               wr_ue,
    input  logic               wr_of,
    output err_rec_t           rec
);

    localparam int SW = (N > 1) ? $clog2(N) : 1;

    err_rec_t      rec_q, base, rec_d;
    logic          any, multi, hit_any, miss_any;
    logic [SW-1:0] first;

    errlog_pick #(.N(N)) u_pick (
        .vld   (ev_vld),
        .any   (any),
        .multi (multi),
        .first (first)
    );

    always_comb begin
        hit_any  = 1'b0;
        miss_any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ev_vld[i] && (ev_loc[i] == rec_q.loc)) hit_any  = 1'b1;
            if (ev_vld[i] && (ev_loc[i] != rec_q.loc)) miss_any = 1'b1;
        end
    end

    always_comb begin
        base = rec_q;
        if (stat_we) begin
            if (!wr_v) begin
                base = '0;
            end else begin
                if (!wr_ue) base.ue = 1'b0;
                if (!wr_of) base.of = 1'b0;
            end
        end
        rec_d = base;
        if (any) begin
            rec_d.ue = base.ue | (|(ev_vld & ev_ue));
            if (multi) rec_d.of = 1'b1;
            if (!base.v) begin
                rec_d.v   = 1'b1;
                rec_d.loc = ev_loc[first];
                rec_d.oth = sat_inc(base.oth, multi);
            end else begin
                rec_d.rpt = sat_inc(base.rpt, hit_any);
                rec_d.oth = sat_inc(base.oth, miss_any);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (cold_rst) rec_q <= '0;
        else          rec_q <= rec_d;
    end

    assign rec = rec_q;

    // R3
    loc_hold_chk: assert property (@(posedge clk) disable iff (cold_rst)
        (rec_q.v && !stat_we) |=> $stable(rec_q.loc));

    // R4
    of_set_chk: assert property (@(posedge clk) disable iff (cold_rst)
        multi |=> rec_q.of);

    // R1
    ue_set_chk: assert property (@(posedge clk) disable iff (cold_rst)
        (|(ev_vld & ev_ue)) |=> rec_q.ue);

    // R5
    rpt_sat_chk: assert property (@(posedge clk) disable iff (cold_rst)
        (rec_q.v && (rec_q.rpt == '1) && !stat_we) |=> (rec_q.rpt == '1));

    // R4
    oth_step_chk: assert property (@(posedge clk) disable iff (cold_rst)
        (rec_q.v && !stat_we) |=>
        ((rec_q.oth == $past(rec_q.oth)) || (rec_q.oth == $past(rec_q.oth) + 1'b1)));

endmodule

// File: rtl/err_syndrome_logger.sv
module err_syndrome_logger import errlog_pkg::*; #(
    parameter int NUM_PRIV = 4,
    parameter int NUM_SHR  = 3
) (
    input  logic                      clk,
    input  logic                      cold_rst,
    input  logic                      warm_rst,
    input  logic [NUM_PRIV-1:0]       prv_ev_vld,
    input  logic [NUM_PRIV-1:0]       prv_ev_ue,
    input  logic [NUM_PRIV*LVL_W-1:0] prv_ev_lvl,
    input  logic [NUM_PRIV*WAY_W-1:0] prv_ev_way,
    input  logic [NUM_PRIV*IDX_W-1:0] prv_ev_idx,
    input  logic [NUM_SHR-1:0]        shr_ev_vld,
    input  logic [NUM_SHR-1:0]        shr_ev_ue,
    input  logic [NUM_SHR*LVL_W-1:0]  shr_ev_lvl,
    input  logic [NUM_SHR*WAY_W-1:0]  shr_ev_way,
    input  logic [NUM_SHR*IDX_W-1:0]  shr_ev_idx,
    input  logic                      csr_we,
    input  logic [1:0]                csr_addr,
    input  logic [CSR_W-1:0]          csr_wdata,
    output logic [CSR_W-1:0]          csr_rdata,
    output logic [1:0]                fault_irq,
    output logic [1:0]                err_irq
);

    err_loc_t [NUM_PRIV-1:0] prv_loc;
    err_loc_t [NUM_SHR-1:0]  shr_loc;
    err_rec_t                rec_prv, rec_shr, rec_sel;
    err_rec_t [1:0]          recs;
    logic                    sel_q;
    logic [1:0][1:0]         ctl_q;
    logic [1:0]              stat_we;
    logic                    unused_wdata;

    for (genvar i = 0; i < NUM_PRIV; i++) begin : g_prv_loc
        assign prv_loc[i] = {prv_ev_lvl[i*LVL_W +: LVL_W],
                             prv_ev_way[i*WAY_W +: WAY_W],
                             prv_ev_idx[i*IDX_W +: IDX_W]};
    end

    for (genvar i = 0; i < NUM_SHR; i++) begin : g_shr_loc
        assign shr_loc[i] = {shr_ev_lvl[i*LVL_W +: LVL_W],
                             shr_ev_way[i*WAY_W +: WAY_W],
                             shr_ev_idx[i*IDX_W +: IDX_W]};
    end

    assign stat_we[0] = csr_we && (csr_addr == CSR_STAT) && !sel_q;
    assign stat_we[1] = csr_we && (csr_addr == CSR_STAT) &&  sel_q;

    errlog_record #(.N(NUM_PRIV)) u_rec_prv (
        .clk      (clk),
        .cold_rst (cold_rst),
        .ev_vld   (prv_ev_vld),
        .ev_ue    (prv_ev_ue),
        .ev_loc   (prv_loc),
        .stat_we  (stat_we[0]),
        .wr_v     (csr_wdata[ST_V]),
        .wr_ue    (csr_wdata[ST_UE]),
        .wr_of    (csr_wdata[ST_OF]),
        .rec      (rec_prv)
    );

    errlog_record #(.N(NUM_SHR)) u_rec_shr (
        .clk      (clk),
        .cold_rst (cold_rst),
        .ev_vld   (shr_ev_vld),
        .ev_ue    (shr_ev_ue),
        .ev_loc   (shr_loc),
        .stat_we  (stat_we[1]),
        .wr_v     (csr_wdata[ST_V]),
        .wr_ue    (csr_wdata[ST_UE]),
        .wr_of    (csr_wdata[ST_OF]),
        .rec      (rec_shr)
    );

    assign recs = {rec_shr, rec_prv};

    always_ff @(posedge clk) begin
        if (cold_rst || warm_rst) begin
            sel_q <= 1'b0;
            ctl_q <= '0;
        end else if (csr_we) begin
            if (csr_addr == CSR_SEL) sel_q <= csr_wdata[0];
            if (csr_addr == CSR_CTL) ctl_q[sel_q] <= csr_wdata[1:0];
        end
    end

    for (genvar r = 0; r < 2; r++) begin : g_irq
        assign fault_irq[r] = recs[r].v  & ctl_q[r][0];
        assign err_irq[r]   = recs[r].ue & ctl_q[r][1];
    end

    assign rec_sel = sel_q ? rec_shr : rec_prv;

    always_comb begin
        case (csr_addr)
            CSR_SEL:  csr_rdata = {{(CSR_W-1){1'b0}}, sel_q};
            CSR_CTL:  csr_rdata = {{(CSR_W-2){1'b0}}, ctl_q[sel_q]};
            CSR_STAT: csr_rdata = {rec_sel.v, rec_sel.ue, rec_sel.of, {(CSR_W-3){1'b0}}};
            default:  csr_rdata = {{(CSR_W-MISC_W){1'b0}}, rec_sel.rpt, rec_sel.oth, rec_sel.loc};
        endcase
    end

    assign unused_wdata = ^csr_wdata[ST_OF-1:2];

    // R6
    sel_stable_chk: assert property (@(posedge clk) disable iff (cold_rst)
        (!warm_rst && !(csr_we && (csr_addr == CSR_SEL))) |=> $stable(sel_q));

    // R8
    err_irq_hold_chk: assert property (@(posedge clk) disable iff (cold_rst)
        (err_irq[0] && !stat_we[0] && !warm_rst) |=> err_irq[0]);

endmodule

// File: tb/tb_err_syndrome_logger.sv
`timescale 1ns/1ps
module tb_err_syndrome_logger;
    import errlog_pkg::*;

    localparam int NP = 4;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic cold_rst = 1'b1;
    logic warm_rst = 1'b0;
    logic [NP-1:0] prv_vld = '0, prv_ue = '0;
    logic [NS-1:0] shr_vld = '0, shr_ue = '0;
    logic [LVL_W-1:0] plvl [NP];
    logic [WAY_W-1:0] pway [NP];
    logic [IDX_W-1:0] pidx [NP];
    logic [LVL_W-1:0] slvl [NS];
    logic [WAY_W-1:0] sway [NS];
    logic [IDX_W-1:0] sidx [NS];
    logic [NP*LVL_W-1:0] prv_lvl_f;
    logic [NP*WAY_W-1:0] prv_way_f;
    logic [NP*IDX_W-1:0] prv_idx_f;
    logic [NS*LVL_W-1:0] shr_lvl_f;
    logic [NS*WAY_W-1:0] shr_way_f;
    logic [NS*IDX_W-1:0] shr_idx_f;
    logic csr_we = 1'b0;
    logic [1:0] csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [1:0] fault_irq, err_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            prv_lvl_f[i*LVL_W +: LVL_W] = plvl[i];
            prv_way_f[i*WAY_W +: WAY_W] = pway[i];
            prv_idx_f[i*IDX_W +: IDX_W] = pidx[i];
        end
        for (int i = 0; i < NS; i++) begin
            shr_lvl_f[i*LVL_W +: LVL_W] = slvl[i];
            shr_way_f[i*WAY_W +: WAY_W] = sway[i];
            shr_idx_f[i*IDX_W +: IDX_W] = sidx[i];
        end
    end

    err_syndrome_logger #(.NUM_PRIV(NP), .NUM_SHR(NS)) dut (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .prv_ev_vld(prv_vld), .prv_ev_ue(prv_ue),
        .prv_ev_lvl(prv_lvl_f), .prv_ev_way(prv_way_f), .prv_ev_idx(prv_idx_f),
        .shr_ev_vld(shr_vld), .shr_ev_ue(shr_ue),
        .shr_ev_lvl(shr_lvl_f), .shr_ev_way(shr_way_f), .shr_ev_idx(shr_idx_f),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .fault_irq(fault_irq), .err_irq(err_irq)
    );

    function automatic logic [31:0] loc_word(input int l, input int w, input int x);
        return (32'(l) << 12) | (32'(w) << 8) | 32'(x);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic fire_prv(input logic [NP-1:0] m, input logic [NP-1:0] u);
        @(negedge clk);
        prv_vld = m; prv_ue = u;
        @(negedge clk);
        prv_vld = '0; prv_ue = '0;
    endtask

    task automatic fire_shr(input logic [NS-1:0] m, input logic [NS-1:0] u);
        @(negedge clk);
        shr_vld = m; shr_ue = u;
        @(negedge clk);
        shr_vld = '0; shr_ue = '0;
    endtask

    task automatic t_reset();
        chk_rd("R10 cold sel", 2'd0, 32'h0);
        chk_rd("R10 cold status", 2'd2, 32'h0);
        chk_rd("R10 cold misc", 2'd3, 32'h0);
        chk("R10 cold irqs", {28'h0, fault_irq, err_irq}, 32'h0);
    endtask

    task automatic t_capture();
        wr(2'd1, 32'h3);
        fire_prv(4'b0100, 4'b0100);
        chk_rd("R1 status", 2'd2, 32'hC000_0000);
        chk_rd("R1 misc", 2'd3, loc_word(1, 5, 'h3C));
        chk("R7 fault_irq", {30'h0, fault_irq}, 32'h1);
        chk("R8 err_irq", {30'h0, err_irq}, 32'h1);
    endtask

    task automatic t_repeat();
        fire_prv(4'b0001, 4'b0000);
        chk_rd("R3 repeat", 2'd3, loc_word(1, 5, 'h3C) | (32'd1 << 22));
        fire_prv(4'b0010, 4'b0000);
        chk_rd("R3 other", 2'd3, loc_word(1, 5, 'h3C) | (32'd1 << 22) | (32'd1 << 14));
        chk_rd("R3 status", 2'd2, 32'hC000_0000);
    endtask

    task automatic t_multi_valid();
        fire_prv(4'b1011, 4'b0000);
        chk_rd("R4 misc", 2'd3, loc_word(1, 5, 'h3C) | (32'd2 << 22) | (32'd2 << 14));
        chk_rd("R4 status", 2'd2, 32'hE000_0000);
    endtask

    task automatic t_clear_flags();
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R8 write one keeps", {30'h0, err_irq}, 32'h1);
        wr(2'd2, 32'hA000_0000);
        chk_rd("R8 ue cleared", 2'd2, 32'hA000_0000);
        chk("R8 err_irq low", {30'h0, err_irq}, 32'h0);
        chk("R7 fault stays", {30'h0, fault_irq}, 32'h1);
        wr(2'd2, 32'h8000_0000);
        chk_rd("R9 of cleared", 2'd2, 32'h8000_0000);
        wr(2'd2, 32'h0);
        chk_rd("R9 status cleared", 2'd2, 32'h0);
        chk_rd("R9 misc cleared", 2'd3, 32'h0);
        chk("R7 fault low", {30'h0, fault_irq}, 32'h0);
    endtask

    task automatic t_first_collide();
        fire_prv(4'b1110, 4'b0000);
        chk_rd("R2 misc", 2'd3, loc_word(2, 3, 'h11) | (32'd1 << 14));
        chk_rd("R2 status", 2'd2, 32'hA000_0000);
        chk("R2 err_irq", {30'h0, err_irq}, 32'h0);
    endtask

    task automatic t_saturate();
        wr(2'd2, 32'h0);
        plvl[0] = 2'd0; pway[0] = 4'd0; pidx[0] = 8'h01;
        fire_prv(4'b0001, 4'b0000);
        for (int k = 0; k < 256; k++) fire_prv(4'b0001, 4'b0000);
        chk_rd("R5 repeat saturated", 2'd3, (32'd255 << 22) | 32'h1);
        fire_prv(4'b0001, 4'b0000);
        chk_rd("R5 repeat held", 2'd3, (32'd255 << 22) | 32'h1);
    endtask

    task automatic t_select();
        fire_shr(3'b001, 3'b001);
        chk_rd("R6 rec0 status kept", 2'd2, 32'h8000_0000);
        chk_rd("R6 rec0 misc kept", 2'd3, (32'd255 << 22) | 32'h1);
        chk("R7 shared fault disabled", {30'h0, fault_irq}, 32'h1);
        chk("R8 shared err disabled", {30'h0, err_irq}, 32'h0);
        wr(2'd0, 32'h1);
        chk_rd("R6 sel readback", 2'd0, 32'h1);
        chk_rd("R6 rec1 status", 2'd2, 32'hC000_0000);
        chk_rd("R6 rec1 misc", 2'd3, loc_word(3, 15, 'hFF));
        wr(2'd1, 32'h3);
        chk_rd("R6 rec1 ctl", 2'd1, 32'h3);
        chk("R7 shared fault", {30'h0, fault_irq}, 32'h3);
        chk("R8 shared err", {30'h0, err_irq}, 32'h2);
    endtask

    task automatic t_warm();
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
        chk_rd("R10 warm sel", 2'd0, 32'h0);
        chk_rd("R10 warm ctl", 2'd1, 32'h0);
        chk("R10 warm irqs", {28'h0, fault_irq, err_irq}, 32'h0);
        chk_rd("R10 warm rec0 status", 2'd2, 32'h8000_0000);
        chk_rd("R10 warm rec0 misc", 2'd3, (32'd255 << 22) | 32'h1);
        wr(2'd0, 32'h1);
        chk_rd("R10 warm rec1 status", 2'd2, 32'hC000_0000);
        chk_rd("R10 warm rec1 misc", 2'd3, loc_word(3, 15, 'hFF));
    endtask

    task automatic t_cold();
        @(negedge clk); cold_rst = 1'b1;
        @(negedge clk); cold_rst = 1'b0;
        chk_rd("R10 cold again sel", 2'd0, 32'h0);
        chk_rd("R10 cold rec0", 2'd2, 32'h0);
        wr(2'd0, 32'h1);
        chk_rd("R10 cold rec1 status", 2'd2, 32'h0);
        chk_rd("R10 cold rec1 misc", 2'd3, 32'h0);
    endtask

    initial begin
        plvl[0] = 2'd1; pway[0] = 4'd5; pidx[0] = 8'h3C;
        plvl[1] = 2'd2; pway[1] = 4'd3; pidx[1] = 8'h11;
        plvl[2] = 2'd1; pway[2] = 4'd5; pidx[2] = 8'h3C;
        plvl[3] = 2'd0; pway[3] = 4'd7; pidx[3] = 8'h99;
        slvl[0] = 2'd3; sway[0] = 4'hF; sidx[0] = 8'hFF;
        slvl[1] = 2'd1; sway[1] = 4'h2; sidx[1] = 8'h40;
        slvl[2] = 2'd2; sway[2] = 4'h6; sidx[2] = 8'h0A;
        repeat (3) @(negedge clk);
        cold_rst = 1'b0;
        t_reset();
        t_capture();
        t_repeat();
        t_multi_valid();
        t_clear_flags();
        t_first_collide();
        t_saturate();
        t_select();
        t_warm();
        t_cold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule